// File: doc/BRIEF.md
# Port-Group Forwarding Mask Resolver

This block works out the set of egress ports for one layer-2 frame in a small Ethernet switch. It keeps one table of port-group masks. Each mask has one bit for each physical port, plus a top bit for the CPU port. For every request it reads three entries from that table and outputs their bitwise AND:

- a destination entry, taken from the MAC-table result or, on a miss, from a flood selector chosen by frame class;
- an aggregation entry, indexed by a 4-bit link-aggregation code, which keeps exactly one member of a trunk for each flow;
- a source entry, indexed by the ingress port, which holds the port-to-port forwarding matrix.

A simple configuration port writes and reads table entries and the five flood selectors. Reads are combinational. One request is accepted on every clock. The result comes out of a fixed two-stage pipeline.

Table layout:

| Indices | Use |
|---|---|
| 0 to 63 | Destination entries |
| 64 to 79 | Aggregation entries, at 64 + code |
| 80 to 90 | Source entries, at 80 + ingress port |

Index 57 is a permanent drop entry. Indices 58 to 63 hold the default CPU and flood groups.

Top module: `pgm_resolver`

## Requirements
- R1: After reset, every table entry reads zero, except the source entries. Source entry 80+i reads all ones, including CPU bit 11, with only bit i cleared (entry 80 = 0xFFE, entry 90 = 0xBFF).
- R2: Frame class codes are 0 unknown unicast, 1 non-IP multicast, 2 IPv4 multicast, 3 IPv6 multicast and 4 broadcast. The flood selector for class c sits at configuration address 128+c. After reset the selectors read 59, 60, 61, 62 and 63 in class order.
- R3: The output mask equals the AND of three table entries: the destination entry, entry 64 + aggregation code, and entry 80 + ingress port.
- R4: When the hit flag is 1, the destination index is the request's 6-bit index. When the hit flag is 0, the destination index is the current flood selector value for the frame's class.
- R5: A miss with a class code of 5, 6 or 7 resolves to index 57 and gives an all-zero mask.
- R6: Entry 57 always reads zero and ignores writes. Any lookup that resolves to it gives an all-zero mask.
- R7: An ingress port number of 11 or more gives an all-zero mask.
- R8: out_valid and out_mask for a request sampled at clock edge k appear after edge k+1 and never earlier. Requests on consecutive cycles give results on consecutive cycles.
- R9: A configuration write that shares its sampling edge with a request does not affect that request. It does affect a request sampled on the next edge.
- R10: Configuration addresses 91 to 127 and 133 to 255 read zero, including after a write to them.
- R11: A write to address i, for i from 0 to 90 except 57, stores all 12 data bits in entry i. cfg_rdata shows the addressed value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | Lookup request strobe |
| req_hit | input | 1 | MAC-table hit flag |
| req_dest | input | 6 | Destination index from the MAC-table entry |
| req_class | input | 3 | Frame class code used on a miss |
| req_aggr | input | 4 | Link-aggregation code |
| req_port | input | 4 | Ingress port number |
| out_valid | output | 1 | Result valid |
| out_mask | output | 12 | Egress mask (bit 11 is the CPU port) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Configuration read data |

## Verification
The bench builds the block with its default parameters: 11 ports, a 6-bit destination index, a 4-bit aggregation code and a 4-bit port number. With these values every reserved destination index is reachable. So are every aggregation entry and every source entry. Port numbers 11 to 15 can be driven, which exercises the invalid-ingress case. Class codes above 4 can be driven, which exercises the invalid-class case. Both unmapped address bands of the 8-bit configuration space can be reached, so out-of-range reads and writes can be tested.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int NCLASS     = 5;   // frame classes with a flood selector
  localparam int DROP_IDX   = 57;  // permanent empty entry
  localparam int FLOOD_DFLT = 59;  // default selector of class 0, +1 per class

  typedef enum logic [2:0] {
    FC_UCAST = 3'd0,
    FC_MCAST = 3'd1,
    FC_IP4MC = 3'd2,
    FC_IP6MC = 3'd3,
    FC_BCAST = 3'd4
  } fclass_e;
endpackage

// File: rtl/pgm_table.sv
module pgm_table #(
  parameter int NUM_PORTS = 11,
  parameter int SRC_BASE  = 80,
  parameter int NUM_ENT   = 91,
  parameter int IDX_W     = 7,
  parameter int NRD       = 4,
  localparam int MASK_W   = NUM_PORTS + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [MASK_W-1:0]              wr_data,
  input  logic [NRD-1:0][IDX_W-1:0]      rd_idx,
  output logic [NRD-1:0][MASK_W-1:0]     rd_mask
);
  import pgm_pkg::*;

  logic [MASK_W-1:0] ent [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    if (e == DROP_IDX) begin : g_drop
      assign ent[e] = '0;
    end else begin : g_reg
      localparam logic [MASK_W-1:0] RSTV =
        (e >= SRC_BASE) ? ~(MASK_W'(1) << (e - SRC_BASE)) : '0;
      logic              q;
      logic [MASK_W-1:0] val_q;
      logic              ld;
      assign ld = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= RSTV;
        else if (ld) val_q <= wr_data;
      end
      assign q      = 1'b0;
      assign ent[e] = val_q;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      rd_mask[r] = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
        if (rd_idx[r] == IDX_W'(e)) rd_mask[r] = ent[e];
      end
    end
  end
endmodule

// File: rtl/pgm_dest_sel.sv
module pgm_dest_sel #(
  parameter int DEST_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [2:0]        sel_cls,
  input  logic [DEST_W-1:0] sel_wdata,
  output logic [DEST_W-1:0] sel_rdata,
  input  logic              hit,
  input  logic [DEST_W-1:0] mac_idx,
  input  logic [2:0]        cls,
  output logic [IDX_W-1:0]  dest_idx
);
  import pgm_pkg::*;

  logic [DEST_W-1:0] sel_q [NCLASS];

  for (genvar c = 0; c < NCLASS; c++) begin : g_sel
    logic ld;
    assign ld = sel_we && (sel_cls == 3'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel_q[c] <= DEST_W'(FLOOD_DFLT + c);
      else if (ld) sel_q[c] <= sel_wdata;
    end
  end

  always_comb begin
    sel_rdata = '0;
    for (int c = 0; c < NCLASS; c++) begin
      if (sel_cls == 3'(c)) sel_rdata = sel_q[c];
    end
  end

  always_comb begin
    dest_idx = IDX_W'(DROP_IDX);
    if (hit) begin
      dest_idx = IDX_W'(mac_idx);
    end else begin
      for (int c = 0; c < NCLASS; c++) begin
        if (cls == 3'(c)) dest_idx = IDX_W'(sel_q[c]);
      end
    end
  end
endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
  import pgm_pkg::*;
#(
  parameter int NUM_PORTS  = 11,
  parameter int DEST_W     = 6,
  parameter int AGGR_W     = 4,
  parameter int PORT_W     = 4,
  localparam int MASK_W    = NUM_PORTS + 1,
  localparam int AGGR_BASE = 1 << DEST_W,
  localparam int SRC_BASE  = AGGR_BASE + (1 << AGGR_W),
  localparam int NUM_ENT   = SRC_BASE + NUM_PORTS,
  localparam int IDX_W     = $clog2(NUM_ENT + 1),
  localparam int ADDR_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic [DEST_W-1:0] req_dest,
  input  logic [2:0]        req_class,
  input  logic [AGGR_W-1:0] req_aggr,
  input  logic [PORT_W-1:0] req_port,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MASK_W-1:0] cfg_wdata,
  output logic [MASK_W-1:0] cfg_rdata
);
  localparam int FLOOD_BASE = 1 << IDX_W;
  localparam int NRD        = 4;   // destination, aggregation, source, config

  // configuration decode
  logic tbl_sel, fld_sel;
  logic [DEST_W-1:0] fld_rdata;
  assign tbl_sel = (int'(cfg_addr) < NUM_ENT);
  assign fld_sel = (int'(cfg_addr) >= FLOOD_BASE) &&
                   (int'(cfg_addr) < FLOOD_BASE + NCLASS);

  // index generation
  logic [IDX_W-1:0] dst_idx, agg_idx, src_idx;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][MASK_W-1:0] rd_mask;

  pgm_dest_sel #(.DEST_W(DEST_W), .IDX_W(IDX_W)) u_dsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (cfg_we && fld_sel),
    .sel_cls   (cfg_addr[2:0]),
    .sel_wdata (cfg_wdata[DEST_W-1:0]),
    .sel_rdata (fld_rdata),
    .hit       (req_hit),
    .mac_idx   (req_dest),
    .cls       (req_class),
    .dest_idx  (dst_idx)
  );

  assign agg_idx = IDX_W'(AGGR_BASE) + IDX_W'(req_aggr);
  assign src_idx = (int'(req_port) < NUM_PORTS) ?
                   IDX_W'(SRC_BASE) + IDX_W'(req_port) : '1;

  assign rd_idx[0] = dst_idx;
  assign rd_idx[1] = agg_idx;
  assign rd_idx[2] = src_idx;
  assign rd_idx[3] = cfg_addr[IDX_W-1:0];

  pgm_table #(
    .NUM_PORTS (NUM_PORTS),
    .SRC_BASE  (SRC_BASE),
    .NUM_ENT   (NUM_ENT),
    .IDX_W     (IDX_W),
    .NRD       (NRD)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we && tbl_sel),
    .wr_idx  (cfg_addr[IDX_W-1:0]),
    .wr_data (cfg_wdata),
    .rd_idx  (rd_idx),
    .rd_mask (rd_mask)
  );

  always_comb begin
    cfg_rdata = '0;
    if (tbl_sel)      cfg_rdata = rd_mask[3];
    else if (fld_sel) cfg_rdata = MASK_W'(fld_rdata);
  end

  // stage 1: capture the three masks
  logic              s1_vld_d, s1_vld_q;
  logic [MASK_W-1:0] s1_dm_q, s1_am_q, s1_sm_q;
  assign s1_vld_d = req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_dm_q <= '0;
      s1_am_q <= '0;
      s1_sm_q <= '0;
    end else if (req_valid) begin
      s1_dm_q <= rd_mask[0];
      s1_am_q <= rd_mask[1];
      s1_sm_q <= rd_mask[2];
    end
  end

  // stage 2: combine
  logic [MASK_W-1:0] res_d, res_q;
  logic              vld_q;
  assign res_d = s1_dm_q & s1_am_q & s1_sm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= s1_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (s1_vld_q) res_q <= res_d;
  end

  assign out_valid = vld_q;
  assign out_mask  = res_q;
endmodule

// File: rtl/pgm_resolver_chk.sv
module pgm_resolver_chk #(
  parameter int NUM_PORTS = 11,
  parameter int DEST_W    = 6,
  parameter int AGGR_W    = 4,
  parameter int PORT_W    = 4,
  parameter int ADDR_W    = 8,
  localparam int MASK_W   = NUM_PORTS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_hit,
  input logic [DEST_W-1:0] req_dest,
  input logic [2:0]        req_class,
  input logic [PORT_W-1:0] req_port,
  input logic              out_valid,
  input logic [MASK_W-1:0] out_mask,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [MASK_W-1:0] cfg_rdata
);
  localparam int NENT  = (1 << DEST_W) + (1 << AGGR_W) + NUM_PORTS;
  localparam int FBASE = 1 << (ADDR_W - 1);

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 out_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ##2 !out_valid); // R8
  AST_BAD_PORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_port) >= NUM_PORTS) |-> ##2 (out_mask == '0)); // R7
  AST_BAD_CLASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hit && req_class > 3'd4) |-> ##2 (out_mask == '0)); // R5
  AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit && req_dest == DEST_W'(57)) |-> ##2 (out_mask == '0)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(cfg_addr) >= NENT && int'(cfg_addr) < FBASE) ||
     int'(cfg_addr) >= FBASE + 5) |-> (cfg_rdata == '0)); // R10
  AST_DROP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(57)) |-> (cfg_rdata == '0)); // R6
endmodule

bind pgm_resolver pgm_resolver_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DEST_W    (DEST_W),
  .AGGR_W    (AGGR_W),
  .PORT_W    (PORT_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_hit   (req_hit),
  .req_dest  (req_dest),
  .req_class (req_class),
  .req_port  (req_port),
  .out_valid (out_valid),
  .out_mask  (out_mask),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata)
);

// File: tb/pgm_resolver_tb.sv
module pgm_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_hit;
  logic [5:0]  req_dest;
  logic [2:0]  req_class;
  logic [3:0]  req_aggr, req_port;
  logic        out_valid;
  logic [11:0] out_mask;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [11:0] cfg_wdata, cfg_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pgm_resolver u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_hit(req_hit), .req_dest(req_dest),
    .req_class(req_class), .req_aggr(req_aggr), .req_port(req_port),
    .out_valid(out_valid), .out_mask(out_mask),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  typedef struct packed {
    logic        hit;
    logic [5:0]  dest;
    logic [2:0]  cls;
    logic [3:0]  aggr;
    logic [3:0]  port;
    logic [11:0] exp;
    logic [3:0]  req;
  } vec_t;

  // table set up by the configuration phase:
  // e3=0x008 e20=0x0F0 e58=0x800 e59=0x7FF e60=0x00F e61=0x0F0 e62=0xF00
  // e63=0xFFF, aggregation all 0xFFF except code 5 = 0xF5F, source at reset
  localparam vec_t VEC [12] = '{
    '{1'b1, 6'd3,  3'd0, 4'd0, 4'd0,  12'h008, 4'd3},  // R3 hit unicast
    '{1'b1, 6'd3,  3'd0, 4'd0, 4'd3,  12'h000, 4'd3},  // R3 own port blocked
    '{1'b1, 6'd20, 3'd0, 4'd5, 4'd1,  12'h050, 4'd3},  // R3 aggregation trim
    '{1'b0, 6'd3,  3'd0, 4'd1, 4'd2,  12'h7FB, 4'd4},  // R4 unknown unicast
    '{1'b0, 6'd3,  3'd1, 4'd0, 4'd0,  12'h00E, 4'd4},  // R4 non-IP multicast
    '{1'b0, 6'd3,  3'd2, 4'd0, 4'd4,  12'h0E0, 4'd4},  // R4 IPv4 multicast
    '{1'b0, 6'd3,  3'd3, 4'd0, 4'd10, 12'hB00, 4'd4},  // R4 IPv6 multicast
    '{1'b0, 6'd3,  3'd4, 4'd5, 4'd5,  12'hF5F, 4'd4},  // R4 broadcast
    '{1'b1, 6'd58, 3'd0, 4'd0, 4'd7,  12'h800, 4'd3},  // R3 CPU group
    '{1'b0, 6'd3,  3'd6, 4'd0, 4'd0,  12'h000, 4'd5},  // R5 bad class
    '{1'b1, 6'd57, 3'd0, 4'd0, 4'd0,  12'h000, 4'd6},  // R6 drop entry
    '{1'b1, 6'd63, 3'd0, 4'd0, 4'd12, 12'h000, 4'd7}   // R7 bad ingress
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic [7:0] a, input logic [11:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic lookup(input string tag, input logic h, input logic [5:0] d,
                        input logic [2:0] c, input logic [3:0] ag,
                        input logic [3:0] p, input logic [11:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_hit = h; req_dest = d; req_class = c;
    req_aggr = ag; req_port = p;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 no early valid", out_valid, 0);
    @(negedge clk);
    chk("R8 valid after two edges", out_valid, 1);
    chk(tag, out_mask, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_hit = 1'b0; req_dest = '0;
    req_class = '0; req_aggr = '0; req_port = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R8 out_valid low after reset", out_valid, 0);
    cfg_read("R1 entry 0 reset", 8'd0, 12'h000);
    cfg_read("R1 entry 63 reset", 8'd63, 12'h000);
    cfg_read("R1 entry 70 reset", 8'd70, 12'h000);
    cfg_read("R1 source 80 reset", 8'd80, 12'hFFE);
    cfg_read("R1 source 90 reset", 8'd90, 12'hBFF);
    for (int c = 0; c < 5; c++)
      cfg_read("R2 flood selector reset", 8'(128 + c), 12'(59 + c));

    // configuration
    cfg_write(8'd3, 12'h008);
    cfg_write(8'd20, 12'h0F0);
    cfg_write(8'd58, 12'h800);
    cfg_write(8'd59, 12'h7FF);
    cfg_write(8'd60, 12'h00F);
    cfg_write(8'd61, 12'h0F0);
    cfg_write(8'd62, 12'hF00);
    cfg_write(8'd63, 12'hFFF);
    for (int a = 0; a < 16; a++) cfg_write(8'(64 + a), 12'hFFF);
    cfg_write(8'd69, 12'hF5F);
    cfg_read("R11 entry 20 write readback", 8'd20, 12'h0F0);
    cfg_read("R11 entry 69 write readback", 8'd69, 12'hF5F);

    // vector table
    for (int i = 0; i < 12; i++) begin
      lookup($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].hit, VEC[i].dest,
             VEC[i].cls, VEC[i].aggr, VEC[i].port, VEC[i].exp);
    end

    // R6: drop entry ignores writes
    cfg_write(8'd57, 12'hFFF);
    cfg_read("R6 entry 57 reads zero", 8'd57, 12'h000);
    lookup("R6 drop after write", 1'b1, 6'd57, 3'd0, 4'd0, 4'd1, 12'h000);

    // R10: unmapped addresses
    cfg_write(8'd100, 12'hABC);
    cfg_read("R10 address 100", 8'd100, 12'h000);
    cfg_write(8'd200, 12'h123);
    cfg_read("R10 address 200", 8'd200, 12'h000);
    cfg_read("R10 address 133", 8'd133, 12'h000);

    // R4: reprogram the unknown-unicast selector to group 20
    cfg_write(8'd128, 12'd20);
    cfg_read("R2 selector write readback", 8'd128, 12'd20);
    lookup("R4 reprogrammed flood", 1'b0, 6'd0, 3'd0, 4'd0, 4'd0, 12'h0F0);

    // R9 and R8: write together with a request, then back-to-back request
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'd3; cfg_wdata = 12'h004;
    req_valid = 1'b1; req_hit = 1'b1; req_dest = 6'd3; req_aggr = 4'd0; req_port = 4'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 back-to-back not yet valid", out_valid, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 first of pair valid", out_valid, 1);
    chk("R9 same-cycle write not seen", out_mask, 12'h008);
    @(negedge clk);
    chk("R8 second of pair valid", out_valid, 1);
    chk("R9 next-cycle lookup sees write", out_mask, 12'h004);
    @(negedge clk);
    chk("R8 valid drops after pair", out_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule